// File: doc/BRIEF.md
# Segment-Based Address Translator

This block turns a 16-bit virtual address into a physical address. It uses a small table of segment descriptors held in flip-flops. The top two bits of the address pick a descriptor. The remaining bits are an offset into that segment. Each descriptor stores four things:
- a base address;
- an exclusive upper bound on the offset;
- a valid flag;
- a writable flag.

A request is translated in one combinational pass and the result is captured in an output register. Every request returns either the base plus the offset, or a fault code that explains why the access was refused.

The table is loaded through a configuration write port. A write only takes effect when the privilege input is high, which models a supervisor reloading the descriptors on a context switch. A write attempted without privilege changes nothing and raises a one-cycle denial flag.

Requests and responses each use a valid/ready handshake. A response appears in the cycle after its request is accepted. It is held until the consumer takes it.

Top module: `seg_xlat_unit`

## Requirements
- R1: Address bits 15:14 select descriptor 0..3 and bits 13:0 are the offset. When no fault applies, the response carries fault code 0 and physical address (base + offset) modulo 2^16.
- R2: When the offset is greater than or equal to the selected descriptor's bound, the response carries fault code 2 and physical address 0. This fault takes priority over fault code 3.
- R3: When the selected descriptor is not valid, the response carries fault code 1 and physical address 0. This fault takes priority over every other fault.
- R4: A write request to a descriptor whose writable flag is 0 gets fault code 3 and physical address 0. Read requests to such a descriptor translate normally.
- R5: A table write with cfg_we=1 and cfg_priv=1 loads entry cfg_idx from cfg_base, cfg_limit, cfg_valid and cfg_writable. A write with cfg_priv=0 leaves the table unchanged. A write with cfg_priv=0 drives cfg_denied high for exactly the following cycle. cfg_denied is low in every other cycle.
- R6: A request is accepted on a clock edge where req_valid and req_ready are both high. Its response is presented on rsp_valid in the next cycle. req_ready equals (not rsp_valid) or rsp_ready. While rsp_valid is high and rsp_ready is low, rsp_paddr and rsp_fault hold their values.
- R7: After reset, rsp_valid and cfg_denied are low and every descriptor is invalid, so any request returns fault code 1.
- R8: A table write takes effect for requests accepted on later edges. A request accepted on the same edge as the write is translated with the old entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_priv | input | 1 | Writer is privileged |
| cfg_idx | input | 2 | Descriptor index to load |
| cfg_base | input | 16 | New base address |
| cfg_limit | input | 15 | New exclusive offset bound |
| cfg_valid | input | 1 | New valid flag |
| cfg_writable | input | 1 | New writable flag |
| cfg_denied | output | 1 | Pulse after an unprivileged table write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 16 | Virtual address |
| req_write | input | 1 | Access is a store |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 16 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 ok, 1 invalid, 2 bound, 3 write-protect |

## Verification
The bench builds the block with its default parameters: a 16-bit virtual address, two selector bits (four descriptors), and a 16-bit physical address. This makes the bound values 0x0800 and 0x1400 reachable exactly at their edges, and lets a base of 0xF000 plus a large offset wrap past the top of the physical space. The parameters also keep all four descriptors small enough to load, invalidate and overload within a short run. With these values, the bench can exercise together every fault priority pair, a same-edge table write against a request, and a consumer that periodically stalls.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_BOUND   = 2'd2,
        FLT_WPROT   = 2'd3
    } fault_e;

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
    parameter int NSEG   = 4,
    parameter int IDX_W  = 2,
    parameter int BASE_W = 16,
    parameter int LIM_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              priv_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic [LIM_W-1:0]  lim_i,
    input  logic              vld_i,
    input  logic              wr_i,
    output logic [BASE_W-1:0] base_o [NSEG],
    output logic [LIM_W-1:0]  lim_o  [NSEG],
    output logic              vld_o  [NSEG],
    output logic              wr_o   [NSEG],
    output logic              denied_o
);

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [LIM_W-1:0]  lim;
        logic [BASE_W-1:0] base;
    } desc_t;

    typedef struct packed {
        desc_t [NSEG-1:0] tbl;
        logic             denied;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.denied = 1'b0;
        if (we_i) begin
            if (priv_i) begin
                st_d.tbl[idx_i].vld  = vld_i;
                st_d.tbl[idx_i].wr   = wr_i;
                st_d.tbl[idx_i].lim  = lim_i;
                st_d.tbl[idx_i].base = base_i;
            end else begin
                st_d.denied = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NSEG; g++) begin : g_out
        assign base_o[g] = st_q.tbl[g].base;
        assign lim_o[g]  = st_q.tbl[g].lim;
        assign vld_o[g]  = st_q.tbl[g].vld;
        assign wr_o[g]   = st_q.tbl[g].wr;
    end

    assign denied_o = st_q.denied;

endmodule

// File: rtl/seg_xlat_check.sv
module seg_xlat_check
    import seg_xlat_pkg::*;
#(
    parameter int NSEG  = 4,
    parameter int VA_W  = 16,
    parameter int SEL_W = 2,
    parameter int PA_W  = 16,
    parameter int LIM_W = 15
) (
    input  logic [VA_W-1:0]  addr_i,
    input  logic             write_i,
    input  logic [PA_W-1:0]  base_i [NSEG],
    input  logic [LIM_W-1:0] lim_i  [NSEG],
    input  logic             vld_i  [NSEG],
    input  logic             wr_i   [NSEG],
    output logic [PA_W-1:0]  paddr_o,
    output fault_e           fault_o
);

    localparam int OFF_W = VA_W - SEL_W;

    logic [SEL_W-1:0] sel;
    logic [OFF_W-1:0] off;
    logic [LIM_W-1:0] off_ext;
    logic             over_bound;

    assign sel        = addr_i[VA_W-1 -: SEL_W];
    assign off        = addr_i[OFF_W-1:0];
    assign off_ext    = LIM_W'(off);
    assign over_bound = off_ext >= lim_i[sel];

    always_comb begin
        paddr_o = '0;
        fault_o = FLT_NONE;
        if (!vld_i[sel]) begin
            fault_o = FLT_INVALID;
        end else if (over_bound) begin
            fault_o = FLT_BOUND;
        end else if (write_i && !wr_i[sel]) begin
            fault_o = FLT_WPROT;
        end else begin
            paddr_o = base_i[sel] + PA_W'(off);
        end
    end

endmodule

// File: rtl/seg_rsp_stage.sv
module seg_rsp_stage
    import seg_xlat_pkg::*;
#(
    parameter int PA_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid_i,
    output logic            in_ready_o,
    input  logic [PA_W-1:0] paddr_i,
    input  fault_e          fault_i,
    output logic            out_valid_o,
    input  logic            out_ready_i,
    output logic [PA_W-1:0] paddr_o,
    output fault_e          fault_o
);

    typedef struct packed {
        logic            vld;
        logic [PA_W-1:0] paddr;
        fault_e          fault;
    } state_t;

    state_t st_d, st_q;

    assign in_ready_o = !st_q.vld || out_ready_i;

    always_comb begin
        st_d = st_q;
        if (in_ready_o) begin
            st_d.vld = in_valid_i;
            if (in_valid_i) begin
                st_d.paddr = paddr_i;
                st_d.fault = fault_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vld   <= 1'b0;
            st_q.paddr <= '0;
            st_q.fault <= FLT_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.vld;
    assign paddr_o     = st_q.paddr;
    assign fault_o     = st_q.fault;

endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
    import seg_xlat_pkg::*;
#(
    parameter int VA_W  = 16,
    parameter int SEL_W = 2,
    parameter int PA_W  = 16,
    localparam int NSEG  = 1 << SEL_W,
    localparam int OFF_W = VA_W - SEL_W,
    localparam int LIM_W = OFF_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_priv,
    input  logic [SEL_W-1:0] cfg_idx,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [LIM_W-1:0] cfg_limit,
    input  logic             cfg_valid,
    input  logic             cfg_writable,
    output logic             cfg_denied,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_addr,
    input  logic             req_write,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_fault
);

    logic [PA_W-1:0]  t_base [NSEG];
    logic [LIM_W-1:0] t_lim  [NSEG];
    logic             t_vld  [NSEG];
    logic             t_wr   [NSEG];
    logic [PA_W-1:0]  x_paddr;
    fault_e           x_fault;
    fault_e           r_fault;

    seg_desc_table #(
        .NSEG(NSEG), .IDX_W(SEL_W), .BASE_W(PA_W), .LIM_W(LIM_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .we_i(cfg_we), .priv_i(cfg_priv), .idx_i(cfg_idx),
        .base_i(cfg_base), .lim_i(cfg_limit),
        .vld_i(cfg_valid), .wr_i(cfg_writable),
        .base_o(t_base), .lim_o(t_lim), .vld_o(t_vld), .wr_o(t_wr),
        .denied_o(cfg_denied)
    );

    seg_xlat_check #(
        .NSEG(NSEG), .VA_W(VA_W), .SEL_W(SEL_W), .PA_W(PA_W), .LIM_W(LIM_W)
    ) u_check (
        .addr_i(req_addr), .write_i(req_write),
        .base_i(t_base), .lim_i(t_lim), .vld_i(t_vld), .wr_i(t_wr),
        .paddr_o(x_paddr), .fault_o(x_fault)
    );

    seg_rsp_stage #(
        .PA_W(PA_W)
    ) u_rsp (
        .clk(clk), .rst_n(rst_n),
        .in_valid_i(req_valid), .in_ready_o(req_ready),
        .paddr_i(x_paddr), .fault_i(x_fault),
        .out_valid_o(rsp_valid), .out_ready_i(rsp_ready),
        .paddr_o(rsp_paddr), .fault_o(r_fault)
    );

    assign rsp_fault = r_fault;

endmodule

// File: rtl/seg_xlat_unit_chk.sv
module seg_xlat_unit_chk #(
    parameter int PA_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_we,
    input logic            cfg_priv,
    input logic            cfg_denied,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [PA_W-1:0] rsp_paddr,
    input logic [1:0]      rsp_fault
);

    // R6
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

    // R6
    accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_valid);

    // R6
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |-> !req_ready);

    // R3
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault != 2'd0 |-> rsp_paddr == '0);

    // R5
    denied_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !cfg_priv |=> cfg_denied);

    // R5
    denied_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && !cfg_priv) |=> !cfg_denied);

endmodule

bind seg_xlat_unit seg_xlat_unit_chk #(.PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
    .cfg_denied(cfg_denied), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault)
);

// File: tb/tb_seg_xlat_unit.sv
`timescale 1ns/1ps
module tb_seg_xlat_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_priv = 1'b0, cfg_valid = 1'b0, cfg_writable = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [15:0] cfg_base = '0;
    logic [14:0] cfg_limit = '0;
    logic        cfg_denied;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [15:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    always #2.5 clk = ~clk;

    seg_xlat_unit dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
        .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .cfg_valid(cfg_valid), .cfg_writable(cfg_writable), .cfg_denied(cfg_denied),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit bp_mode = 1'b0;
    bit finished = 1'b0;

    logic [15:0] m_base [4];
    logic [14:0] m_lim  [4];
    bit          m_v    [4];
    bit          m_w    [4];

    logic [17:0] exp_q [$];
    string       tag_q [$];

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [17:0] model(logic [15:0] a, bit wr);
        logic [1:0]  s;
        logic [13:0] o;
        s = a[15:14];
        o = a[13:0];
        if (!m_v[s])                  return {2'd1, 16'h0};
        else if ({1'b0, o} >= m_lim[s]) return {2'd2, 16'h0};
        else if (wr && !m_w[s])       return {2'd3, 16'h0};
        else                          return {2'd0, 16'(m_base[s] + 16'(o))};
    endfunction

    task automatic cfg_wr(int idx, logic [15:0] b, logic [14:0] l, bit v, bit w, bit priv);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_priv = priv; cfg_idx = 2'(idx);
        cfg_base = b; cfg_limit = l; cfg_valid = v; cfg_writable = w;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (priv) begin
            m_base[idx] = b; m_lim[idx] = l; m_v[idx] = v; m_w[idx] = w;
        end
        @(negedge clk);
        chk(cfg_denied == !priv, "R5 denied flag", 32'(cfg_denied), 32'(!priv));
        @(negedge clk);
        chk(cfg_denied == 1'b0, "R5 denied one cycle", 32'(cfg_denied), 32'd0);
    endtask

    task automatic send(logic [15:0] a, bit wr, string tag);
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = a; req_write = wr;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk);
        exp_q.push_back(model(a, wr));
        tag_q.push_back(tag);
        #1 req_valid = 1'b0;
        if (!bp_mode) begin
            @(negedge clk);
            chk(rsp_valid == 1'b1, "R6 response next cycle", 32'(rsp_valid), 32'd1);
        end
    endtask

    // monitor / scoreboard
    bit          prev_stall = 1'b0;
    logic [17:0] prev_rsp = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                chk({rsp_fault, rsp_paddr} == prev_rsp && rsp_valid, "R6 hold under stall",
                    32'({rsp_fault, rsp_paddr}), 32'(prev_rsp));
            if (rsp_valid && rsp_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected response", 32'({rsp_fault, rsp_paddr}), 32'd0);
                end else begin
                    logic [17:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({rsp_fault, rsp_paddr} == e, t, 32'({rsp_fault, rsp_paddr}), 32'(e));
                end
            end
            prev_stall = rsp_valid && !rsp_ready;
            prev_rsp   = {rsp_fault, rsp_paddr};
        end
    end

    always @(posedge clk) begin
        cyc++;
        #1 rsp_ready = !bp_mode || (cyc % 3 != 2);
    end

    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_base[i] = '0; m_lim[i] = '0; m_v[i] = 1'b0; m_w[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R7 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk(cfg_denied == 1'b0, "R7 cfg_denied after reset", 32'(cfg_denied), 32'd0);
        chk(req_ready == 1'b1, "R6 ready when empty", 32'(req_ready), 32'd1);
        send(16'h0240, 1'b0, "R7 entry invalid after reset");

        cfg_wr(0, 16'h4000, 15'h0800, 1'b1, 1'b0, 1'b1);
        cfg_wr(1, 16'h4800, 15'h1400, 1'b1, 1'b1, 1'b1);
        cfg_wr(2, 16'hF000, 15'h1000, 1'b1, 1'b0, 1'b1);
        cfg_wr(3, 16'h0000, 15'h3000, 1'b1, 1'b1, 1'b1);

        send(16'h0240, 1'b0, "R1 code seg read");
        send(16'h4050, 1'b0, "R1 data seg read");
        send(16'h8FFF, 1'b0, "R1 shared seg top offset");
        send(16'hC123, 1'b1, "R1 stack write");
        send(16'h07FF, 1'b0, "R2 last offset inside bound");
        send(16'h0800, 1'b0, "R2 offset equal to bound");
        send(16'h53FF, 1'b1, "R2 data last inside");
        send(16'h5400, 1'b1, "R2 data at bound");
        send(16'h0100, 1'b1, "R4 write to read-only");
        send(16'h0100, 1'b0, "R4 read of read-only");
        send(16'h0900, 1'b1, "R2 bound over write-protect");
        send(16'h4060, 1'b1, "R4 write to writable");

        cfg_wr(3, 16'h1234, 15'h0000, 1'b0, 1'b0, 1'b1);
        send(16'hFFFF, 1'b1, "R3 invalid over bound and protect");
        send(16'hC000, 1'b0, "R3 invalid seg read");

        cfg_wr(1, 16'h9000, 15'h0010, 1'b1, 1'b0, 1'b0);
        send(16'h4050, 1'b1, "R5 unprivileged write ignored");

        cfg_wr(3, 16'hF000, 15'h3000, 1'b1, 1'b1, 1'b1);
        send(16'hD000, 1'b0, "R1 wrap modulo 2^16");

        // same-edge table write and request
        wait (exp_q.size() == 0);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_priv = 1'b1; cfg_idx = 2'd1;
        cfg_base = 16'h6000; cfg_limit = 15'h1400; cfg_valid = 1'b1; cfg_writable = 1'b1;
        req_valid = 1'b1; req_addr = 16'h4010; req_write = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 ready for same-edge test", 32'(req_ready), 32'd1);
        @(posedge clk);
        exp_q.push_back(model(16'h4010, 1'b0));
        tag_q.push_back("R8 same-edge uses old entry");
        m_base[1] = 16'h6000;
        #1 cfg_we = 1'b0; req_valid = 1'b0;
        send(16'h4010, 1'b0, "R8 later request uses new entry");

        bp_mode = 1'b1;
        for (int k = 0; k < 12; k++)
            send(16'(16'h4000 + 16'(k * 16'h0111)), k[0], "R6 backpressure stream");
        bp_mode = 1'b0;

        wait (exp_q.size() == 0);
        repeat (4) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule